// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block opens and closes the transmit gates of up to eight queues from a repeating schedule. The schedule is a list of up to sixteen windows. Each window holds a gate mask and the time at which it ends, measured from the start of the cycle. A free-running nanosecond time input sets the pace. The block keeps two list banks. One bank drives the gates, and the host fills the other bank while the first one runs.

The host loads the shadow bank one window at a time, giving each window its mask and its interval. The block adds the intervals up into end times as they arrive. The host then raises a trigger carrying the list length, the requested cycle time and a base time. The block checks the request and works out how many whole cycles must pass before the change. It makes the swap at that cycle boundary. Two flags report progress: one for "request accepted, count being computed" and one for "new list not yet active". Three commands put the block into the disabled, enabled or reset state. A small table holds one maximum frame size per queue.

Top module: `tgate_sched`

## Requirements
- R1: After rst_n, or after a reset command (cmd 2) issued from another state, the block is in this condition: state_o=2, act_sel_o=0, all gates closed, both list banks empty, cfg_change_o=0, cfg_pending_o=0, and every max_sdu_o entry is 2048.
- R2: The gates are registered. Bit q of gate_o equals bit q of the current window's mask, one clock after the window is reached. This holds only while state_o=1 (enabled) and the active list is not empty. Otherwise every gate is closed one clock after the condition holds.
- R3: Window end times are running sums of the written intervals. The end time of the last window of a list is replaced by the requested cycle time. gate_close_o lane q (bits q*TW upward) carries the current window's end time when gate q is open, and zero when it is closed.
- R4: The window index increments when the cycle-relative time reaches the current window's end. It returns to 0 when the relative time reaches the effective cycle, which is the requested cycle minus 4 ns.
- R5: A window write pulses wr_rej_o and leaves the shadow entry unchanged in any of these cases: the interval is zero, the interval is below MIN_WIN (10,000 ns), or a change is in flight (cfg_change_o or cfg_pending_o set).
- R6: A trigger pulses trig_rej_o and changes no flag in any of these cases: the length is 0 or greater than NWIN, the requested cycle is below MIN_CYC (1,000,000 ns), any of the first `length` shadow entries has not been validly written, or a change is already in flight.
- R7: An accepted trigger sets both cfg_change_o and cfg_pending_o. cfg_change_o clears once the change count is known, within TW+4 clocks.
- R8: The change count is ceil((base - now) / effective cycle) when base > now, and 1 otherwise. Counting starts once the count is loaded. The swap happens at the count-th cycle boundary: act_sel_o toggles, cfg_pending_o clears and window 0 of the new list starts.
- R9: If the active list is empty while the block is enabled and a loaded change is pending, the swap happens on the next clock and the new cycle starts at that time.
- R10: An enable command (cmd 1) from another state restarts the cycle at the current time in window 0. A command equal to the current state, or code 3, has no effect.
- R11: A max-SDU write sets the entry of queue sdu_q_i to sdu_val_i. A reset restores every entry to 2048.
- R12: A swap marks every shadow entry unwritten, so the host must write a new list before the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | TW | Free-running time in ns |
| cmd_vld_i | input | 1 | State command strobe |
| cmd_i | input | 2 | 0 disable, 1 enable, 2 reset |
| wr_en_i | input | 1 | Shadow window write strobe |
| wr_idx_i | input | IW | Window index, written in ascending order |
| wr_mask_i | input | NQ | Gate mask of the window |
| wr_ival_i | input | TW | Window interval in ns |
| trig_i | input | 1 | Change request strobe |
| trig_len_i | input | LW | Number of windows in the new list |
| trig_cyc_i | input | TW | Requested cycle time in ns |
| trig_base_i | input | TW | Base time of the new list |
| sdu_wr_i | input | 1 | Max-SDU write strobe |
| sdu_q_i | input | QW | Queue selected by the max-SDU write |
| sdu_val_i | input | 16 | Max-SDU value |
| gate_o | output | NQ | Gate state per queue, 1 = open |
| gate_close_o | output | NQ*TW | Gate-close time per queue in the current window |
| win_o | output | IW | Current window index |
| act_sel_o | output | 1 | Bank that drives the gates |
| state_o | output | 2 | Current state, same codes as cmd_i |
| cfg_change_o | output | 1 | Accepted request whose count is not yet loaded |
| cfg_pending_o | output | 1 | New list not yet active |
| wr_rej_o | output | 1 | Window write rejected (one-clock pulse) |
| trig_rej_o | output | 1 | Change request rejected (one-clock pulse) |
| max_sdu_o | output | NQ*16 | Max SDU per queue |

## Verification
A bad window index or cycle start shows on gate_o as the wrong mask one clock after the time input crosses a window end. The bench therefore samples in the middle of each window, so a wrong boundary is visible at once. A wrong change count or a wrong active-bank bit keeps the old masks running for one or more whole extra cycles, or brings the new masks in too early. This is caught by checks made in the middle of the cycles just before and just after the expected boundary. A lost acceptance check shows up as flags that rise when they should not, or as a later list whose masks differ from the ones the host wrote.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  typedef enum logic [1:0] {
    ST_DIS = 2'd0,
    ST_EN  = 2'd1,
    ST_RST = 2'd2
  } tgs_state_e;

  localparam int          SDU_W    = 16;
  localparam logic [15:0] SDU_DFLT = 16'd2048;
  localparam int          WRAP_TRIM = 4;
endpackage

// File: rtl/tgs_bank.sv
module tgs_bank #(
  parameter int NQ   = 8,
  parameter int NWIN = 16,
  parameter int TW   = 32,
  parameter int IW   = 4,
  parameter int LW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          act_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [NQ-1:0] wr_mask_i,
  input  logic [TW-1:0] wr_end_i,
  input  logic          fin_en_i,
  input  logic [LW-1:0] fin_len_i,
  input  logic [TW-1:0] fin_cyc_i,
  input  logic [TW-1:0] fin_end_i,
  input  logic [IW-1:0] rd_win_i,
  output logic [NQ-1:0] rd_mask_o,
  output logic [TW-1:0] rd_end_o,
  output logic [LW-1:0] act_len_o,
  output logic [TW-1:0] act_cyc_o,
  input  logic [IW-1:0] prev_idx_i,
  output logic [TW-1:0] prev_end_o
);
  logic [NQ-1:0] mask_q [2][NWIN];
  logic [TW-1:0] end_q  [2][NWIN];
  logic [LW-1:0] len_q  [2];
  logic [TW-1:0] cyc_q  [2];

  logic          sh;
  logic [IW-1:0] last_idx;

  assign sh       = ~act_i;
  assign last_idx = IW'(fin_len_i - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        len_q[b] <= '0;
        cyc_q[b] <= '0;
        for (int w = 0; w < NWIN; w++) begin
          mask_q[b][w] <= '0;
          end_q[b][w]  <= '0;
        end
      end
    end else if (clr_i) begin
      for (int b = 0; b < 2; b++) begin
        len_q[b] <= '0;
        cyc_q[b] <= '0;
        for (int w = 0; w < NWIN; w++) begin
          mask_q[b][w] <= '0;
          end_q[b][w]  <= '0;
        end
      end
    end else begin
      if (wr_en_i) begin
        mask_q[sh][wr_idx_i] <= wr_mask_i;
        end_q[sh][wr_idx_i]  <= wr_end_i;
      end
      if (fin_en_i) begin
        len_q[sh]           <= fin_len_i;
        cyc_q[sh]           <= fin_cyc_i;
        end_q[sh][last_idx] <= fin_end_i;
      end
    end
  end

  assign rd_mask_o  = mask_q[act_i][rd_win_i];
  assign rd_end_o   = end_q[act_i][rd_win_i];
  assign act_len_o  = len_q[act_i];
  assign act_cyc_o  = cyc_q[act_i];
  assign prev_end_o = end_q[sh][prev_idx_i];
endmodule

// File: rtl/tgs_cdiv.sv
module tgs_cdiv #(
  parameter int W  = 33,
  localparam int CNW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0]   rem_q, quo_q, dvs_q;
  logic [CNW-1:0] cnt_q;
  logic           busy_q, done_q;

  // one restoring step: returns {new remainder, quotient bit}
  function automatic logic [W:0] div_step(input logic [W-1:0] rem,
                                          input logic          nxt_bit,
                                          input logic [W-1:0] dvs);
    logic [W:0] trial;
    trial = {rem, nxt_bit};
    if (trial >= {1'b0, dvs}) return {W'(trial - {1'b0, dvs}), 1'b1};
    else                      return {trial[W-1:0], 1'b0};
  endfunction

  logic [W:0] step;
  assign step = div_step(rem_q, quo_q[W-1], dvs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; dvs_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else if (clr_i) begin
      busy_q <= 1'b0; done_q <= 1'b0; cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= dvd_i;
        dvs_q  <= dvs_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= step[W:1];
        quo_q <= {quo_q[W-2:0], step[0]};
        cnt_q <= cnt_q + CNW'(1);
        if (cnt_q == CNW'(W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/tgs_timer.sv
module tgs_timer #(
  parameter int TW = 32,
  parameter int IW = 4,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [TW-1:0] now_i,
  input  logic          start_i,
  input  logic          en_i,
  input  logic          armed_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic [LW-1:0] act_len_i,
  input  logic [TW-1:0] act_cyc_i,
  input  logic [TW-1:0] act_end_i,
  output logic [IW-1:0] win_o,
  output logic          act_o,
  output logic          swap_o,
  output logic          bound_o
);
  logic [TW-1:0] cstart_q, cnt_q, rel;
  logic [IW-1:0] win_q;
  logic          act_q;
  logic          empty, adv;

  assign rel     = now_i - cstart_q;
  assign empty   = (act_len_i == '0);
  assign bound_o = en_i && !empty && (rel >= act_cyc_i);
  assign swap_o  = en_i && armed_i && (empty || (bound_o && cnt_q <= TW'(1)));
  assign adv     = en_i && !empty && !bound_o && (rel >= act_end_i) &&
                   ((LW'(win_q) + LW'(1)) < act_len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cstart_q <= '0; cnt_q <= '0; win_q <= '0; act_q <= 1'b0;
    end else if (clr_i) begin
      cstart_q <= '0; cnt_q <= '0; win_q <= '0; act_q <= 1'b0;
    end else begin
      if (load_i) cnt_q <= load_val_i;
      if (start_i) begin
        cstart_q <= now_i;
        win_q    <= '0;
      end else if (swap_o && empty) begin
        act_q    <= ~act_q;
        cstart_q <= now_i;
        win_q    <= '0;
      end else if (bound_o) begin
        cstart_q <= cstart_q + act_cyc_i;
        win_q    <= '0;
        if (swap_o)                    act_q <= ~act_q;
        else if (armed_i && cnt_q > TW'(1)) cnt_q <= cnt_q - TW'(1);
      end else if (adv) begin
        win_q <= win_q + IW'(1);
      end
    end
  end

  assign win_o = win_q;
  assign act_o = act_q;
endmodule

// File: rtl/tgate_sched.sv
module tgate_sched
  import tgs_pkg::*;
#(
  parameter int NQ      = 8,
  parameter int NWIN    = 16,
  parameter int TW      = 32,
  parameter int MIN_CYC = 1000000,
  parameter int MIN_WIN = 10000,
  localparam int IW = $clog2(NWIN),
  localparam int LW = $clog2(NWIN + 1),
  localparam int QW = $clog2(NQ),
  localparam int DW = TW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    now_i,
  input  logic             cmd_vld_i,
  input  logic [1:0]       cmd_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [NQ-1:0]    wr_mask_i,
  input  logic [TW-1:0]    wr_ival_i,
  input  logic             trig_i,
  input  logic [LW-1:0]    trig_len_i,
  input  logic [TW-1:0]    trig_cyc_i,
  input  logic [TW-1:0]    trig_base_i,
  input  logic             sdu_wr_i,
  input  logic [QW-1:0]    sdu_q_i,
  input  logic [15:0]      sdu_val_i,
  output logic [NQ-1:0]    gate_o,
  output logic [NQ*TW-1:0] gate_close_o,
  output logic [IW-1:0]    win_o,
  output logic             act_sel_o,
  output logic [1:0]       state_o,
  output logic             cfg_change_o,
  output logic             cfg_pending_o,
  output logic             wr_rej_o,
  output logic             trig_rej_o,
  output logic [NQ*16-1:0] max_sdu_o
);
  // ---------------- arithmetic helpers ----------------
  function automatic logic [TW-1:0] eff_cycle(input logic [TW-1:0] req);
    return req - TW'(WRAP_TRIM);
  endfunction

  function automatic logic [TW-1:0] close_of(input logic open, input logic [TW-1:0] wend);
    return open ? wend : '0;
  endfunction

  // numerator of a rounded-up division: diff + divisor - 1
  function automatic logic [DW-1:0] ceil_num(input logic [TW-1:0] base,
                                             input logic [TW-1:0] now,
                                             input logic [TW-1:0] cyc);
    return DW'(base - now) + DW'(cyc) - DW'(1);
  endfunction

  // ---------------- state ----------------
  tgs_state_e st_q;
  logic       chg_q, pend_q, imm_q;
  logic [NWIN-1:0] sh_ok_q;
  logic [15:0]     sdu_q [NQ];
  logic [NQ-1:0]   gate_q;
  logic [TW-1:0]   close_q [NQ];
  logic            wr_rej_q, trig_rej_q;

  // named internal events
  logic cmd_take, clr_evt, start_evt, wr_ok, trig_ok, swap_evt, bound_evt, load_evt;
  logic len_ok, ent_ok, future, armed, en_run;

  logic [NQ-1:0] rd_mask;
  logic [TW-1:0] rd_end, act_cyc, prev_end, wr_end, load_val;
  logic [LW-1:0] act_len;
  logic [IW-1:0] win, prev_idx;
  logic          act;
  logic          div_done;
  logic [DW-1:0] div_quo;

  assign cmd_take  = cmd_vld_i && (cmd_i != 2'd3) && (cmd_i != st_q);
  assign clr_evt   = cmd_take && (cmd_i == ST_RST);
  assign start_evt = cmd_take && (cmd_i == ST_EN);

  assign wr_ok = wr_en_i && !chg_q && !pend_q && (int'(wr_idx_i) < NWIN) &&
                 (wr_ival_i != '0) && (wr_ival_i >= TW'(MIN_WIN));
  assign prev_idx = wr_idx_i - IW'(1);
  assign wr_end   = ((wr_idx_i == '0) ? '0 : prev_end) + wr_ival_i;

  always_comb begin
    ent_ok = 1'b1;
    for (int i = 0; i < NWIN; i++)
      if ((LW'(i) < trig_len_i) && !sh_ok_q[i]) ent_ok = 1'b0;
  end

  assign len_ok  = (trig_len_i != '0) && (int'(trig_len_i) <= NWIN);
  assign trig_ok = trig_i && !chg_q && !pend_q && len_ok && ent_ok &&
                   (trig_cyc_i >= TW'(MIN_CYC));
  assign future  = trig_base_i > now_i;
  assign load_evt = div_done || imm_q;
  assign load_val = imm_q ? TW'(1) : div_quo[TW-1:0];
  assign armed    = pend_q && !chg_q;
  assign en_run   = (st_q == ST_EN);

  // ---------------- sub-blocks ----------------
  tgs_bank #(.NQ(NQ), .NWIN(NWIN), .TW(TW), .IW(IW), .LW(LW)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_evt), .act_i(act),
    .wr_en_i(wr_ok), .wr_idx_i(wr_idx_i), .wr_mask_i(wr_mask_i), .wr_end_i(wr_end),
    .fin_en_i(trig_ok), .fin_len_i(trig_len_i), .fin_cyc_i(eff_cycle(trig_cyc_i)),
    .fin_end_i(trig_cyc_i),
    .rd_win_i(win), .rd_mask_o(rd_mask), .rd_end_o(rd_end),
    .act_len_o(act_len), .act_cyc_o(act_cyc),
    .prev_idx_i(prev_idx), .prev_end_o(prev_end)
  );

  tgs_cdiv #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_evt),
    .start_i(trig_ok && future),
    .dvd_i(ceil_num(trig_base_i, now_i, eff_cycle(trig_cyc_i))),
    .dvs_i(DW'(eff_cycle(trig_cyc_i))),
    .done_o(div_done), .quo_o(div_quo)
  );

  tgs_timer #(.TW(TW), .IW(IW), .LW(LW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_evt), .now_i(now_i),
    .start_i(start_evt), .en_i(en_run), .armed_i(armed),
    .load_i(load_evt), .load_val_i(load_val),
    .act_len_i(act_len), .act_cyc_i(act_cyc), .act_end_i(rd_end),
    .win_o(win), .act_o(act), .swap_o(swap_evt), .bound_o(bound_evt)
  );

  // ---------------- control registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_RST; chg_q <= 1'b0; pend_q <= 1'b0; imm_q <= 1'b0;
      sh_ok_q <= '0; wr_rej_q <= 1'b0; trig_rej_q <= 1'b0;
    end else begin
      wr_rej_q   <= wr_en_i && !wr_ok;
      trig_rej_q <= trig_i && !trig_ok;
      if (cmd_take) st_q <= tgs_state_e'(cmd_i);
      if (clr_evt) begin
        chg_q <= 1'b0; pend_q <= 1'b0; imm_q <= 1'b0; sh_ok_q <= '0;
      end else begin
        imm_q <= trig_ok && !future;
        if (trig_ok)       chg_q <= 1'b1;
        else if (load_evt) chg_q <= 1'b0;
        if (trig_ok)       pend_q <= 1'b1;
        else if (swap_evt) pend_q <= 1'b0;
        if (swap_evt)      sh_ok_q <= '0;
        else if (wr_ok)    sh_ok_q[wr_idx_i] <= 1'b1;
      end
    end
  end

  // ---------------- per-queue outputs ----------------
  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic open_nxt;
    assign open_nxt = en_run && (act_len != '0) && rd_mask[q];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gate_q[q]  <= 1'b0;
        close_q[q] <= '0;
        sdu_q[q]   <= SDU_DFLT;
      end else begin
        gate_q[q]  <= open_nxt;
        close_q[q] <= close_of(open_nxt, rd_end);
        if (clr_evt)                           sdu_q[q] <= SDU_DFLT;
        else if (sdu_wr_i && sdu_q_i == QW'(q)) sdu_q[q] <= sdu_val_i;
      end
    end

    assign gate_close_o[q*TW +: TW] = close_q[q];
    assign max_sdu_o[q*16 +: 16]    = sdu_q[q];
  end

  assign gate_o        = gate_q;
  assign win_o         = win;
  assign act_sel_o     = act;
  assign state_o       = st_q;
  assign cfg_change_o  = chg_q;
  assign cfg_pending_o = pend_q;
  assign wr_rej_o      = wr_rej_q;
  assign trig_rej_o    = trig_rej_q;
endmodule

// File: rtl/tgs_chk.sv
module tgs_chk #(
  parameter int NQ = 8,
  parameter int TW = 32,
  parameter int IW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state_o,
  input logic [NQ-1:0]    gate_o,
  input logic [NQ*TW-1:0] gate_close_o,
  input logic [IW-1:0]    win_o,
  input logic             act_sel_o,
  input logic             cfg_change_o,
  input logic             cfg_pending_o,
  input logic             trig_i,
  input logic             trig_rej_o,
  input logic [NQ*16-1:0] max_sdu_o,
  input logic             clr_evt,
  input logic             swap_evt
);
  logic [NQ-1:0] close_nz;
  always_comb
    for (int q = 0; q < NQ; q++) close_nz[q] = (gate_close_o[q*TW +: TW] != '0);

  // R2
  gates_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd1) |=> (gate_o == '0));

  // R3
  close_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_nz == gate_o);

  // R4
  win_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o != $past(win_o)) |-> (win_o == '0 || win_o == $past(win_o) + IW'(1)));

  // R8
  swap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_sel_o != $past(act_sel_o)) && !$past(clr_evt)) |->
      ($past(swap_evt) && $past(cfg_pending_o) && !$past(cfg_change_o) && !cfg_pending_o));

  // R7
  change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_change_o) |-> ($past(trig_i) && cfg_pending_o));

  // R6
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rej_o |-> !$rose(cfg_pending_o));

  // R11
  sdu_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_evt) |-> (max_sdu_o == {NQ{16'd2048}}));
endmodule

bind tgate_sched tgs_chk #(.NQ(NQ), .TW(TW), .IW(IW)) u_tgs_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .gate_o(gate_o),
  .gate_close_o(gate_close_o), .win_o(win_o), .act_sel_o(act_sel_o),
  .cfg_change_o(cfg_change_o), .cfg_pending_o(cfg_pending_o),
  .trig_i(trig_i), .trig_rej_o(trig_rej_o), .max_sdu_o(max_sdu_o),
  .clr_evt(clr_evt), .swap_evt(swap_evt)
);

// File: tb/tgate_sched_bench.sv
module tgate_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 1000;
  localparam int NQ = 8, TW = 32, IW = 4, LW = 5, QW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] now_r = 32'd1000;
  logic cmd_vld = 0; logic [1:0] cmd = 0;
  logic wr_en = 0; logic [IW-1:0] wr_idx = 0; logic [NQ-1:0] wr_mask = 0; logic [TW-1:0] wr_ival = 0;
  logic trig = 0; logic [LW-1:0] trig_len = 0; logic [TW-1:0] trig_cyc = 0, trig_base = 0;
  logic sdu_wr = 0; logic [QW-1:0] sdu_q = 0; logic [15:0] sdu_val = 0;
  logic [NQ-1:0] gate; logic [NQ*TW-1:0] gclose; logic [IW-1:0] win;
  logic act_sel, cfg_change, cfg_pending, wr_rej, trig_rej;
  logic [1:0] state; logic [NQ*16-1:0] max_sdu;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [TW-1:0] t0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin #1; now_r = now_r + STEP; end

  tgate_sched u_tgate_sched (
    .clk(clk), .rst_n(rst_n), .now_i(now_r), .cmd_vld_i(cmd_vld), .cmd_i(cmd),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_mask_i(wr_mask), .wr_ival_i(wr_ival),
    .trig_i(trig), .trig_len_i(trig_len), .trig_cyc_i(trig_cyc), .trig_base_i(trig_base),
    .sdu_wr_i(sdu_wr), .sdu_q_i(sdu_q), .sdu_val_i(sdu_val),
    .gate_o(gate), .gate_close_o(gclose), .win_o(win), .act_sel_o(act_sel),
    .state_o(state), .cfg_change_o(cfg_change), .cfg_pending_o(cfg_pending),
    .wr_rej_o(wr_rej), .trig_rej_o(trig_rej), .max_sdu_o(max_sdu));

  task automatic check(input string req, input logic [63:0] actual, input logic [63:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  function automatic logic [TW-1:0] close_at(input int q);
    return gclose[q*TW +: TW];
  endfunction

  task automatic wait_rel(input logic [TW-1:0] base, input int rel);
    while (now_r - base < TW'(rel)) @(negedge clk);
  endtask

  task automatic do_write(input int idx, input logic [NQ-1:0] m, input int iv, output logic rej);
    @(negedge clk); wr_en = 1; wr_idx = IW'(idx); wr_mask = m; wr_ival = TW'(iv);
    @(negedge clk); wr_en = 0; rej = wr_rej;
  endtask

  task automatic do_trig(input int len, input int cyc, input logic [TW-1:0] base, output logic rej);
    @(negedge clk); trig = 1; trig_len = LW'(len); trig_cyc = TW'(cyc); trig_base = base;
    @(negedge clk); trig = 0; rej = trig_rej;
  endtask

  task automatic do_cmd(input logic [1:0] c);
    @(negedge clk); cmd_vld = 1; cmd = c;
    @(negedge clk); cmd_vld = 0;
  endtask

  task automatic t_reset_state;
    check("R1 state", state, 2);
    check("R1 active bank", act_sel, 0);
    check("R1 gates", gate, 0);
    check("R1 change flag", cfg_change, 0);
    check("R1 pending flag", cfg_pending, 0);
    check("R1 sdu", max_sdu, {NQ{16'd2048}});
  endtask

  task automatic t_write_rules;
    logic rej;
    do_write(0, 8'h01, 5000, rej);   check("R5 short interval rejected", rej, 1);
    do_write(0, 8'h01, 0, rej);      check("R5 zero interval rejected", rej, 1);
    do_write(0, 8'h01, 200000, rej); check("R5 write 0 accepted", rej, 0);
    do_write(1, 8'h06, 300000, rej); check("R5 write 1 accepted", rej, 0);
    do_write(2, 8'h80, 100000, rej); check("R5 write 2 accepted", rej, 0);
  endtask

  task automatic t_trig_rules;
    logic rej;
    do_trig(0, 1000000, 0, rej);  check("R6 zero length rejected", rej, 1);
    check("R6 no pending after reject", cfg_pending, 0);
    do_trig(3, 500000, 0, rej);   check("R6 short cycle rejected", rej, 1);
    do_trig(4, 1000000, 0, rej);  check("R6 unwritten entry rejected", rej, 1);
    check("R6 no change flag after reject", cfg_change, 0);
  endtask

  task automatic t_accept;
    logic rej;
    do_trig(3, 1000000, 0, rej);
    check("R7 accepted", rej, 0);
    check("R7 change flag set", cfg_change, 1);
    check("R7 pending set", cfg_pending, 1);
    repeat (3) @(negedge clk);
    check("R7 change flag cleared", cfg_change, 0);
    check("R9 no swap while disabled", act_sel, 0);
  endtask

  task automatic t_first_list;
    do_cmd(2'd1);
    t0 = now_r;
    @(negedge clk);
    check("R9 immediate swap on empty active list", act_sel, 1);
    check("R9 pending cleared", cfg_pending, 0);
    wait_rel(t0, 100000);
    check("R2 window 0 mask", gate, 8'h01);
    check("R3 close q0 in window 0", close_at(0), 200000);
    check("R3 close q1 closed", close_at(1), 0);
    wait_rel(t0, 350000);
    check("R2 window 1 mask", gate, 8'h06);
    check("R4 window index 1", win, 1);
    check("R3 running sum q2", close_at(2), 500000);
    check("R3 closed q0 zero", close_at(0), 0);
    wait_rel(t0, 700000);
    check("R2 window 2 mask", gate, 8'h80);
    check("R3 last end forced to cycle", close_at(7), 1000000);
    wait_rel(t0, 1100000);
    check("R4 wrap to window 0", win, 0);
    check("R4 wrap mask", gate, 8'h01);
  endtask

  task automatic t_delayed_swap;
    logic rej;
    do_trig(2, 1000000, 0, rej);
    check("R12 shadow entries unwritten after swap", rej, 1);
    do_write(0, 8'h10, 500000, rej);
    do_write(1, 8'h20, 500000, rej);
    // count = ceil(2500000 / 1999996) = 2
    do_trig(2, 2000000, now_r + 2500000, rej);
    check("R8 accepted", rej, 0);
    do_trig(2, 2000000, 0, rej);
    check("R6 trigger while pending rejected", rej, 1);
    do_write(0, 8'h40, 500000, rej);
    check("R5 write while pending rejected", rej, 1);
    wait_rel(t0, 2300000);
    check("R8 old list after first boundary", act_sel, 1);
    check("R8 still pending", cfg_pending, 1);
    check("R8 old mask", gate, 8'h06);
    wait_rel(t0, 3200000);
    check("R8 swapped at second boundary", act_sel, 0);
    check("R8 pending cleared", cfg_pending, 0);
    check("R5 rejected write left mask", gate, 8'h10);
    wait_rel(t0, 3700000);
    check("R2 new window 1", gate, 8'h20);
    check("R3 new last end forced", close_at(5), 2000000);
  endtask

  task automatic t_disable_enable;
    logic [TW-1:0] t1;
    do_cmd(2'd0);
    @(negedge clk);
    check("R2 gates closed when disabled", gate, 0);
    check("R10 state disabled", state, 0);
    do_cmd(2'd1);
    t1 = now_r - STEP;
    wait_rel(t1, 200000);
    check("R10 restart window 0", gate, 8'h10);
    wait_rel(t1, 750000);
    check("R10 window 1", gate, 8'h20);
    do_cmd(2'd1);
    wait_rel(t1, 1200000);
    check("R10 repeated enable ignored", gate, 8'h20);
  endtask

  task automatic t_sdu_and_reset;
    @(negedge clk); sdu_wr = 1; sdu_q = 3; sdu_val = 16'd1500;
    @(negedge clk); sdu_wr = 0;
    check("R11 sdu write", max_sdu[3*16 +: 16], 1500);
    check("R11 other sdu", max_sdu[2*16 +: 16], 2048);
    do_cmd(2'd2);
    @(negedge clk);
    check("R11 sdu restored", max_sdu[3*16 +: 16], 2048);
    t_reset_state();
    do_cmd(2'd1);
    repeat (300) @(negedge clk);
    check("R1 lists cleared, gates stay closed", gate, 0);
    check("R1 no bank swap", act_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_write_rules();
    t_trig_rules();
    t_accept();
    t_first_list();
    t_delayed_swap();
    t_disable_enable();
    t_sdu_and_reset();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule